// File: doc/BRIEF.md
# Exception Cause and Vector Generator

This block sits at the point where a processor core commits to taking an exception. A one-cycle strobe announces a pending exception, and with it come its class and code, the result of a failed address translation, the relevant status and configuration bits, the interrupt lines and the PC to resume at. On the next clock edge the block presents the handler address, the updated cause word and the exception code. It also presents write strobes and data for the saved-PC registers, and set strobes for the exception-level, error-level and bootstrap-vector flags.

The block covers ordinary exceptions and translation faults, which it converts to exception codes. It also covers TLB refill, interrupts in plain, internally vectored and externally vectored form, cache errors, NMI and soft reset, and debug entry. The handler address is a base plus an offset. The base depends on the bootstrap-vector flag, on the programmable exception base and on the cache-error override. The offset depends on the kind of exception, on the exception-level flag and on the interrupt vector spacing. The core owns the architectural registers and applies the strobes the block produces.

Top module: `exc_vector_gen`

## Requirements
- R1: Outputs are registered. `outValid` is high in exactly the cycle after a cycle with `excValid` high, and is low after reset.
- R2: `excClass` encodes general=0, translation fault=1, NMI=2, soft reset=3, debug=4, and any other value acts as general. A general exception takes its 5-bit code from `excCode` (interrupt=0, cache error=30).
- R3: A translation fault maps `mmuResult` (0 no match, 1 invalid, 2 dirty, 5 bad address) with `mmuAccess` (0 load, 1 store, 2 fetch). No match and invalid give code 3 for a store and 2 otherwise. Dirty gives 1. Bad address gives 5 for a store and 4 otherwise.
- R4: `mmuResult` 3 (read inhibit) and 4 (execute inhibit) give codes 19 and 20 when `inhibitExcEn` is 1, and code 2 when it is 0.
- R5: The default handler offset is 0x180. A no-match translation fault taken with `statusExl`=0 uses 0x000. A cache error (code 30) uses 0x100.
- R6: An interrupt with `causeIv`=0 uses 0x180. With `causeIv`=1 it uses 0x200 when `statusBev`=1 or `intSpacing`=0, and otherwise 0x200 + vector × (`intSpacing`·32).
- R7: With `extIntCtrl`=0 the vector is the index of the highest set bit of `pendingLines` & `intMask`, or 0 when none is set. With `extIntCtrl`=1 the vector is `pendingLines` itself.
- R8: The base is BOOT_BASE+0x200 when `statusBev`=1. A cache error with `cacheOverride`=0 uses UNCACHED_BASE | (`ebase` & 0x1FFFF000). In all other cases the base is `ebase` with bits [11:0] cleared. The handler PC is base + offset.
- R9: For general exceptions with `statusExl`=0: `epcWe` and `exlSet` pulse, `savedPc`=`resumePc`, and cause bit 31 takes `inDelaySlot`. With `statusExl`=1 neither pulses and cause bit 31 is kept.
- R10: For general exceptions, cause bits [6:2] take the exception code and every other cause bit passes through. For NMI, soft reset and debug the cause word is unchanged.
- R11: NMI and soft reset pulse `errPcWe`, `erlSet` and `bevSet` with `savedPc`=`resumePc`, jump to BOOT_BASE, and do not pulse `epcWe`.
- R12: Debug entry pulses `debugEntry`, jumps to BOOT_BASE+0x480, and pulses neither saved-PC strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | One-cycle strobe: exception being taken |
| excClass | input | 3 | Exception class |
| excCode | input | 5 | Code for the general class |
| mmuResult | input | 3 | Translation fault result |
| mmuAccess | input | 2 | Access type of the faulting translation |
| statusExl | input | 1 | Exception-level flag |
| statusBev | input | 1 | Bootstrap-vector flag |
| causeIv | input | 1 | Interrupts use the special vector |
| intSpacing | input | 5 | Interrupt vector spacing |
| pendingLines | input | 8 | Pending interrupt lines or external vector |
| intMask | input | 8 | Interrupt mask bits |
| extIntCtrl | input | 1 | External interrupt controller supplies the vector |
| inhibitExcEn | input | 1 | Read/execute-inhibit faults get their own codes |
| cacheOverride | input | 1 | Cache errors use the programmable base |
| ebase | input | 32 | Programmable exception base |
| resumePc | input | 32 | PC to resume at |
| inDelaySlot | input | 1 | Faulting instruction is in a delay slot |
| causeIn | input | 32 | Current cause word |
| outValid | output | 1 | Results valid |
| newPc | output | 32 | Handler address |
| causeOut | output | 32 | Updated cause word |
| excCodeOut | output | 5 | Selected exception code |
| epcWe | output | 1 | Write saved-PC register |
| errPcWe | output | 1 | Write error-PC register |
| savedPc | output | 32 | Data for the saved-PC writes |
| exlSet | output | 1 | Set the exception-level flag |
| erlSet | output | 1 | Set the error-level flag |
| bevSet | output | 1 | Set the bootstrap-vector flag |
| debugEntry | output | 1 | Enter debug mode |

## Verification
On every cycle the assertions check several properties. The result valid follows the strobe by exactly one cycle. The saved-PC strobe appears only when the exception-level flag was clear. The error-level entry and debug entry never write the ordinary saved PC. The inhibit codes never appear while the inhibit-exception enable is off. The fault-to-code table, the offset and base arithmetic, the priority encoding of the interrupt lines and the preservation of the cause bits need concrete values, and only the bench's directed scenarios can show them.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [2:0] {
    CLS_GENERAL = 3'd0,
    CLS_MMU     = 3'd1,
    CLS_NMI     = 3'd2,
    CLS_SRESET  = 3'd3,
    CLS_DEBUG   = 3'd4
  } excClass_e;

  typedef enum logic [2:0] {
    MMU_NOMATCH = 3'd0,
    MMU_INVALID = 3'd1,
    MMU_DIRTY   = 3'd2,
    MMU_RDINH   = 3'd3,
    MMU_EXINH   = 3'd4,
    MMU_BADADDR = 3'd5
  } mmuRes_e;

  localparam logic [1:0] ACC_STORE = 2'd1;

  localparam logic [CODE_W-1:0] CODE_INT   = 5'd0;
  localparam logic [CODE_W-1:0] CODE_MOD   = 5'd1;
  localparam logic [CODE_W-1:0] CODE_TLBL  = 5'd2;
  localparam logic [CODE_W-1:0] CODE_TLBS  = 5'd3;
  localparam logic [CODE_W-1:0] CODE_ADEL  = 5'd4;
  localparam logic [CODE_W-1:0] CODE_ADES  = 5'd5;
  localparam logic [CODE_W-1:0] CODE_RDINH = 5'd19;
  localparam logic [CODE_W-1:0] CODE_EXINH = 5'd20;
  localparam logic [CODE_W-1:0] CODE_CACHE = 5'd30;

  typedef struct packed {
    logic              general;
    logic              refill;
    logic              interrupt;
    logic              cacheErr;
    logic              errLevel;
    logic              debug;
    logic              firstLevel;
    logic [CODE_W-1:0] code;
  } excStrobe_t;
endpackage

// File: rtl/exc_vec_ctrl.sv
module exc_vec_ctrl
  import exc_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [2:0]        excClass,
  input  logic [CODE_W-1:0] excCode,
  input  logic [2:0]        mmuResult,
  input  logic [1:0]        mmuAccess,
  input  logic              statusExl,
  input  logic              inhibitExcEn,
  output excStrobe_t        strobe
);
  logic isStore;
  logic [CODE_W-1:0] missCode;

  assign isStore  = (mmuAccess == ACC_STORE);
  assign missCode = isStore ? CODE_TLBS : CODE_TLBL;

  always_comb begin
    strobe = '0;
    case (excClass_e'(excClass))
      CLS_MMU: begin
        strobe.general = 1'b1;
        case (mmuRes_e'(mmuResult))
          MMU_NOMATCH: begin
            strobe.code   = missCode;
            strobe.refill = !statusExl;
          end
          MMU_INVALID: strobe.code = missCode;
          MMU_DIRTY:   strobe.code = CODE_MOD;
          MMU_RDINH:   strobe.code = inhibitExcEn ? CODE_RDINH : CODE_TLBL;
          MMU_EXINH:   strobe.code = inhibitExcEn ? CODE_EXINH : CODE_TLBL;
          default:     strobe.code = isStore ? CODE_ADES : CODE_ADEL;
        endcase
      end
      CLS_NMI, CLS_SRESET: strobe.errLevel = 1'b1;
      CLS_DEBUG:           strobe.debug    = 1'b1;
      default: begin
        strobe.general   = 1'b1;
        strobe.code      = excCode;
        strobe.interrupt = (excCode == CODE_INT);
      end
    endcase
    strobe.cacheErr   = strobe.general && (strobe.code == CODE_CACHE);
    strobe.firstLevel = strobe.general && !statusExl;
  end

  // R4
  inhibit_code_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !inhibitExcEn) |-> (strobe.code != CODE_RDINH && strobe.code != CODE_EXINH));

  // R2
  class_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> $onehot0({strobe.general, strobe.errLevel, strobe.debug}));
endmodule

// File: rtl/exc_vec_datapath.sv
module exc_vec_datapath
  import exc_vec_pkg::*;
#(
  parameter int              ADDR_W        = 32,
  parameter int              PEND_W        = 8,
  parameter int              SPACE_W       = 5,
  parameter logic [ADDR_W-1:0] BOOT_BASE     = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'hA000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  excStrobe_t         strobe,
  input  logic               statusExl,
  input  logic               statusBev,
  input  logic               causeIv,
  input  logic [SPACE_W-1:0] intSpacing,
  input  logic [PEND_W-1:0]  pendingLines,
  input  logic [PEND_W-1:0]  intMask,
  input  logic               extIntCtrl,
  input  logic               cacheOverride,
  input  logic [ADDR_W-1:0]  ebase,
  input  logic [ADDR_W-1:0]  resumePc,
  input  logic               inDelaySlot,
  input  logic [31:0]        causeIn,
  output logic               outValid,
  output logic [ADDR_W-1:0]  newPc,
  output logic [31:0]        causeOut,
  output logic [CODE_W-1:0]  excCodeOut,
  output logic               epcWe,
  output logic               errPcWe,
  output logic [ADDR_W-1:0]  savedPc,
  output logic               exlSet,
  output logic               erlSet,
  output logic               bevSet,
  output logic               debugEntry
);
  localparam logic [ADDR_W-1:0] OFF_REFILL  = ADDR_W'(32'h000);
  localparam logic [ADDR_W-1:0] OFF_CACHE   = ADDR_W'(32'h100);
  localparam logic [ADDR_W-1:0] OFF_GENERAL = ADDR_W'(32'h180);
  localparam logic [ADDR_W-1:0] OFF_INTVEC  = ADDR_W'(32'h200);
  localparam logic [ADDR_W-1:0] OFF_DEBUG   = ADDR_W'(32'h480);
  localparam logic [ADDR_W-1:0] PAGE_MASK   = ~ADDR_W'(32'hFFF);
  localparam logic [ADDR_W-1:0] SEG_MASK    = ADDR_W'(32'h1FFF_F000);
  localparam int CODE_LSB = 2;
  localparam int BD_BIT   = 31;

  logic [PEND_W-1:0] maskedLines;
  logic [PEND_W-1:0] vecIdx;
  logic [ADDR_W-1:0] offset, base, pcNext;
  logic [31:0]       causeNext;

  assign maskedLines = pendingLines & intMask;

  always_comb begin
    vecIdx = '0;
    if (extIntCtrl) begin
      vecIdx = pendingLines;
    end else begin
      for (int i = 0; i < PEND_W; i++) begin
        if (maskedLines[i]) vecIdx = PEND_W'(i);
      end
    end
  end

  always_comb begin
    if (strobe.refill)
      offset = OFF_REFILL;
    else if (strobe.cacheErr)
      offset = OFF_CACHE;
    else if (strobe.interrupt && causeIv) begin
      if (statusBev || intSpacing == '0)
        offset = OFF_INTVEC;
      else
        offset = OFF_INTVEC + ADDR_W'(vecIdx) * ADDR_W'({intSpacing, 5'b0});
    end else
      offset = OFF_GENERAL;

    if (statusBev)
      base = BOOT_BASE + OFF_INTVEC;
    else if (strobe.cacheErr && !cacheOverride)
      base = UNCACHED_BASE | (ebase & SEG_MASK);
    else
      base = ebase & PAGE_MASK;

    if (strobe.errLevel)
      pcNext = BOOT_BASE;
    else if (strobe.debug)
      pcNext = BOOT_BASE + OFF_DEBUG;
    else
      pcNext = base + offset;

    causeNext = causeIn;
    if (strobe.general) begin
      causeNext[CODE_LSB +: CODE_W] = strobe.code;
      if (strobe.firstLevel) causeNext[BD_BIT] = inDelaySlot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      newPc      <= '0;
      causeOut   <= '0;
      excCodeOut <= '0;
      epcWe      <= 1'b0;
      errPcWe    <= 1'b0;
      savedPc    <= '0;
      exlSet     <= 1'b0;
      erlSet     <= 1'b0;
      bevSet     <= 1'b0;
      debugEntry <= 1'b0;
    end else begin
      outValid   <= excValid;
      epcWe      <= excValid && strobe.firstLevel;
      exlSet     <= excValid && strobe.firstLevel;
      errPcWe    <= excValid && strobe.errLevel;
      erlSet     <= excValid && strobe.errLevel;
      bevSet     <= excValid && strobe.errLevel;
      debugEntry <= excValid && strobe.debug;
      if (excValid) begin
        newPc      <= pcNext;
        causeOut   <= causeNext;
        excCodeOut <= strobe.code;
        savedPc    <= resumePc;
      end
    end
  end

  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> outValid);
  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !excValid |=> !outValid);
  // R9
  epc_first_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    epcWe |-> ($past(!statusExl) && outValid));
  // R11
  error_level_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    erlSet |-> (bevSet && errPcWe && !epcWe && !exlSet));
  // R12
  debug_no_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    debugEntry |-> (!epcWe && !errPcWe));
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_vec_pkg::*;
#(
  parameter int                ADDR_W        = 32,
  parameter int                PEND_W        = 8,
  parameter int                SPACE_W       = 5,
  parameter logic [ADDR_W-1:0] BOOT_BASE     = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'hA000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  logic [2:0]         excClass,
  input  logic [4:0]         excCode,
  input  logic [2:0]         mmuResult,
  input  logic [1:0]         mmuAccess,
  input  logic               statusExl,
  input  logic               statusBev,
  input  logic               causeIv,
  input  logic [SPACE_W-1:0] intSpacing,
  input  logic [PEND_W-1:0]  pendingLines,
  input  logic [PEND_W-1:0]  intMask,
  input  logic               extIntCtrl,
  input  logic               inhibitExcEn,
  input  logic               cacheOverride,
  input  logic [ADDR_W-1:0]  ebase,
  input  logic [ADDR_W-1:0]  resumePc,
  input  logic               inDelaySlot,
  input  logic [31:0]        causeIn,
  output logic               outValid,
  output logic [ADDR_W-1:0]  newPc,
  output logic [31:0]        causeOut,
  output logic [4:0]         excCodeOut,
  output logic               epcWe,
  output logic               errPcWe,
  output logic [ADDR_W-1:0]  savedPc,
  output logic               exlSet,
  output logic               erlSet,
  output logic               bevSet,
  output logic               debugEntry
);
  excStrobe_t strobe;

  exc_vec_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .excValid     (excValid),
    .excClass     (excClass),
    .excCode      (excCode),
    .mmuResult    (mmuResult),
    .mmuAccess    (mmuAccess),
    .statusExl    (statusExl),
    .inhibitExcEn (inhibitExcEn),
    .strobe       (strobe)
  );

  exc_vec_datapath #(
    .ADDR_W        (ADDR_W),
    .PEND_W        (PEND_W),
    .SPACE_W       (SPACE_W),
    .BOOT_BASE     (BOOT_BASE),
    .UNCACHED_BASE (UNCACHED_BASE)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .excValid      (excValid),
    .strobe        (strobe),
    .statusExl     (statusExl),
    .statusBev     (statusBev),
    .causeIv       (causeIv),
    .intSpacing    (intSpacing),
    .pendingLines  (pendingLines),
    .intMask       (intMask),
    .extIntCtrl    (extIntCtrl),
    .cacheOverride (cacheOverride),
    .ebase         (ebase),
    .resumePc      (resumePc),
    .inDelaySlot   (inDelaySlot),
    .causeIn       (causeIn),
    .outValid      (outValid),
    .newPc         (newPc),
    .causeOut      (causeOut),
    .excCodeOut    (excCodeOut),
    .epcWe         (epcWe),
    .errPcWe       (errPcWe),
    .savedPc       (savedPc),
    .exlSet        (exlSet),
    .erlSet        (erlSet),
    .bevSet        (bevSet),
    .debugEntry    (debugEntry)
  );
endmodule

// File: tb/test_exc_vector_gen.sv
module test_exc_vector_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excValid = 1'b0;
  logic [2:0] excClass;
  logic [4:0] excCode;
  logic [2:0] mmuResult;
  logic [1:0] mmuAccess;
  logic statusExl, statusBev, causeIv, extIntCtrl, inhibitExcEn, cacheOverride, inDelaySlot;
  logic [4:0] intSpacing;
  logic [7:0] pendingLines, intMask;
  logic [31:0] ebase, resumePc, causeIn;
  logic outValid, epcWe, errPcWe, exlSet, erlSet, bevSet, debugEntry;
  logic [31:0] newPc, causeOut, savedPc;
  logic [4:0] excCodeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_gen i_exc_vector_gen (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excClass(excClass), .excCode(excCode),
    .mmuResult(mmuResult), .mmuAccess(mmuAccess), .statusExl(statusExl), .statusBev(statusBev),
    .causeIv(causeIv), .intSpacing(intSpacing), .pendingLines(pendingLines), .intMask(intMask),
    .extIntCtrl(extIntCtrl), .inhibitExcEn(inhibitExcEn), .cacheOverride(cacheOverride),
    .ebase(ebase), .resumePc(resumePc), .inDelaySlot(inDelaySlot), .causeIn(causeIn),
    .outValid(outValid), .newPc(newPc), .causeOut(causeOut), .excCodeOut(excCodeOut),
    .epcWe(epcWe), .errPcWe(errPcWe), .savedPc(savedPc), .exlSet(exlSet), .erlSet(erlSet),
    .bevSet(bevSet), .debugEntry(debugEntry)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    excClass = 3'd0; excCode = 5'd0; mmuResult = 3'd0; mmuAccess = 2'd0;
    statusExl = 0; statusBev = 0; causeIv = 0; extIntCtrl = 0; inhibitExcEn = 0;
    cacheOverride = 0; inDelaySlot = 0; intSpacing = 0; pendingLines = 0; intMask = 0;
    ebase = 32'h8012_3ABC; resumePc = 32'h0040_1000; causeIn = 32'h1234_5678;
  endtask

  // One strobe; outputs are checked at the negedge after the capturing edge.
  task automatic shot();
    @(negedge clk); excValid = 1'b1;
    @(negedge clk); excValid = 1'b0;
  endtask

  task automatic expectExc(input string tag, input logic [31:0] pc, input logic [4:0] code);
    shot();
    chk({tag, " pc"}, newPc, pc);
    chk({tag, " code"}, {27'd0, excCodeOut}, {27'd0, code});
  endtask

  function automatic logic [31:0] expCause(input logic [4:0] code, input bit first, input bit ds);
    logic [31:0] c;
    c = (causeIn & ~32'h0000_007C) | ({27'd0, code} << 2);
    if (first) c[31] = ds;
    return c;
  endfunction

  task automatic t_reset();
    chk("R1 reset outValid", {31'd0, outValid}, 32'd0);
    chk("R1 reset epcWe", {31'd0, epcWe}, 32'd0);
  endtask

  task automatic t_general();
    defaults();
    excCode = 5'd8; inDelaySlot = 1;
    shot();
    chk("R1 outValid", {31'd0, outValid}, 32'd1);
    chk("R5 R8 general pc", newPc, 32'h8012_3180);
    chk("R2 code", {27'd0, excCodeOut}, 32'd8);
    chk("R9 epcWe", {31'd0, epcWe}, 32'd1);
    chk("R9 exlSet", {31'd0, exlSet}, 32'd1);
    chk("R9 savedPc", savedPc, 32'h0040_1000);
    chk("R10 R9 cause", causeOut, expCause(5'd8, 1, 1));
    @(negedge clk);
    chk("R1 outValid drop", {31'd0, outValid}, 32'd0);
    chk("R9 epcWe drop", {31'd0, epcWe}, 32'd0);
    // Nested: flag already set, cause bit 31 kept
    causeIn = 32'h9234_5678; statusExl = 1; inDelaySlot = 0; excCode = 5'd13;
    shot();
    chk("R9 nested epcWe", {31'd0, epcWe}, 32'd0);
    chk("R9 nested exlSet", {31'd0, exlSet}, 32'd0);
    chk("R10 nested cause", causeOut, expCause(5'd13, 0, 0));
    excClass = 3'd7; excCode = 5'd12; statusExl = 0;
    expectExc("R2 unlisted class", 32'h8012_3180, 5'd12);
  endtask

  task automatic t_mmu();
    defaults();
    excClass = 3'd1;
    mmuResult = 3'd0; mmuAccess = 2'd0;
    expectExc("R3 R5 refill load", 32'h8012_3000, 5'd2);
    mmuAccess = 2'd1;
    expectExc("R3 R5 refill store", 32'h8012_3000, 5'd3);
    statusExl = 1;
    expectExc("R5 nomatch in exl", 32'h8012_3180, 5'd3);
    statusExl = 0; mmuResult = 3'd1;
    expectExc("R3 invalid store", 32'h8012_3180, 5'd3);
    mmuAccess = 2'd2;
    expectExc("R3 invalid fetch", 32'h8012_3180, 5'd2);
    mmuResult = 3'd2; mmuAccess = 2'd1;
    expectExc("R3 dirty", 32'h8012_3180, 5'd1);
    mmuResult = 3'd5;
    expectExc("R3 badaddr store", 32'h8012_3180, 5'd5);
    mmuAccess = 2'd0;
    expectExc("R3 badaddr load", 32'h8012_3180, 5'd4);
    mmuResult = 3'd3; inhibitExcEn = 1;
    expectExc("R4 rdinh en", 32'h8012_3180, 5'd19);
    mmuResult = 3'd4; mmuAccess = 2'd2;
    expectExc("R4 exinh en", 32'h8012_3180, 5'd20);
    inhibitExcEn = 0;
    expectExc("R4 exinh off", 32'h8012_3180, 5'd2);
    mmuResult = 3'd3; mmuAccess = 2'd0;
    expectExc("R4 rdinh off", 32'h8012_3180, 5'd2);
  endtask

  task automatic t_interrupt();
    defaults();
    excCode = 5'd0;
    expectExc("R6 no iv", 32'h8012_3180, 5'd0);
    causeIv = 1;
    expectExc("R6 spacing zero", 32'h8012_3200, 5'd0);
    intSpacing = 5'd1; pendingLines = 8'b0010_0100; intMask = 8'hFF;
    expectExc("R7 R6 highest line", 32'h8012_32A0, 5'd0);
    intMask = 8'h0F;
    expectExc("R7 masked line", 32'h8012_3240, 5'd0);
    intMask = 8'h00;
    expectExc("R7 none pending", 32'h8012_3200, 5'd0);
    extIntCtrl = 1; pendingLines = 8'h03; intSpacing = 5'd2;
    expectExc("R7 external vector", 32'h8012_32C0, 5'd0);
    statusBev = 1;
    expectExc("R6 R8 bev interrupt", 32'hBFC0_0400, 5'd0);
  endtask

  task automatic t_base();
    defaults();
    excCode = 5'd30;
    expectExc("R8 R5 cache uncached", 32'hA012_3100, 5'd30);
    cacheOverride = 1;
    expectExc("R8 cache override", 32'h8012_3100, 5'd30);
    cacheOverride = 0; statusBev = 1;
    expectExc("R8 cache bev", 32'hBFC0_0300, 5'd30);
    excCode = 5'd10;
    expectExc("R8 bev general", 32'hBFC0_0380, 5'd10);
  endtask

  task automatic t_nmi();
    defaults();
    excClass = 3'd2; resumePc = 32'h0000_2468;
    shot();
    chk("R11 nmi pc", newPc, BOOT);
    chk("R11 errPcWe", {31'd0, errPcWe}, 32'd1);
    chk("R11 erl/bev", {30'd0, erlSet, bevSet}, 32'd3);
    chk("R11 epcWe", {31'd0, epcWe}, 32'd0);
    chk("R11 savedPc", savedPc, 32'h0000_2468);
    chk("R10 nmi cause kept", causeOut, causeIn);
    excClass = 3'd3;
    shot();
    chk("R11 soft reset pc", newPc, BOOT);
    chk("R11 soft reset erl", {31'd0, erlSet}, 32'd1);
  endtask

  task automatic t_debug();
    defaults();
    excClass = 3'd4;
    shot();
    chk("R12 debug pc", newPc, BOOT + 32'h480);
    chk("R12 debugEntry", {31'd0, debugEntry}, 32'd1);
    chk("R12 no saves", {30'd0, epcWe, errPcWe}, 32'd0);
    chk("R12 cause kept", causeOut, causeIn);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_general();
    t_mmu();
    t_interrupt();
    t_base();
    t_nmi();
    t_debug();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule